// File: doc/BRIEF.md
# Sequential Single-Branch Despreading Matched Filter

This block forms the matched-filter estimate of one user's symbol inside an interference cancellation stage of a CDMA receiver. A single path branch is built in hardware and reused for every multipath component. For each path the branch reads the user's chips from the residual chip buffer, starting at that path's delay. It removes the user's complex scrambling code with its conjugate, despreads with the real spreading code and keeps a short saturated copy of the despread value. It then weights that value with the conjugate of the path's channel coefficient.

The weighted path results are summed over all active paths and scaled down by an arithmetic shift with saturation. The scaled sum is added to the symbol estimate that the previous detector stage produced, which gives the refined estimate. The chip buffer sits outside the block and is read through a simple address port with one cycle of read latency. Codes, coefficients, delays, spreading factor, path count and previous estimate are plain inputs. They must stay constant from the accepted start until the result is taken. The result leaves through a valid/ready pair. The block keeps `out_valid` high with a stable result until `out_ready` is seen high on a rising edge. No new symbol can begin before that edge.

Top module: `despread_mf`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `out_valid` and `chip_rd` are all low.
- R2: A rising edge that sees `start` high while `busy` is low accepts a symbol. `busy` is high from the next cycle until the edge where the result is taken.
- R3: Each path pass lasts `sf_len`+3 cycles, and passes run in path order 0 to `n_paths`-1. In the first `sf_len` cycles of pass p, `chip_rd` is high with `chip_addr` = delay(p)+n modulo the buffer depth, where n counts 0 up to `sf_len`-1. In the other three cycles `chip_rd` is low. Chip data must arrive on `chip_re`/`chip_im` one cycle after its address.
- R4: Each chip c is multiplied by the conjugate of its scrambling value s. In `scr_code`, bit 2n gives the sign of the real part of chip n and bit 2n+1 gives the sign of its imaginary part (0 means +1, 1 means -1). This gives (c_re·s_re + c_im·s_im) + j(c_im·s_re − c_re·s_im).
- R5: The descrambled chip n is multiplied by spreading value n (`spr_code` bit n, with 0 meaning +1 and 1 meaning -1). These values are summed over the pass. The sum is shifted right arithmetically by 2 and saturated to 8 bits per component.
- R6: The despread value h is multiplied by the conjugate of path coefficient g. Path p's real part is at `coef_flat` bits [16p+7:16p] and its imaginary part at [16p+15:16p+8]. Each result component, (h_re·g_re + h_im·g_im) and (h_im·g_re − h_re·g_im), is saturated to 16 bits.
- R7: The saturated products are summed over all paths. The sum is shifted right arithmetically by 6 and saturated to 8 bits. The previous-stage estimate is then added, and the total is saturated to 8 bits per component.
- R8: `out_valid` rises exactly (`sf_len`+3)×`n_paths` rising edges after the edge that accepted `start`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `y_re`/`y_im` hold their values. The edge that sees both high takes the result, and `out_valid` and `busy` are low from the next cycle.
- R10: `start` is ignored when `busy` is high, including on the edge that takes the result. Such a pulse changes neither the timing nor the value of the symbol in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one symbol (ignored while busy) |
| sf_len | input | 5 | Spreading factor, 1 to 16 |
| n_paths | input | 3 | Number of paths, 1 to 6 |
| scr_code | input | 32 | Scrambling code signs, two bits per chip |
| spr_code | input | 16 | Spreading code signs, one bit per chip |
| coef_flat | input | 96 | Channel coefficients, 16 bits per path |
| dly_flat | input | 36 | Path delays as chip buffer offsets, 6 bits per path |
| y_prev_re | input | 8 | Previous-stage estimate, real part |
| y_prev_im | input | 8 | Previous-stage estimate, imaginary part |
| chip_rd | output | 1 | Chip buffer read strobe |
| chip_addr | output | 6 | Chip buffer read address |
| chip_re | input | 8 | Chip read data, real part (one cycle after address) |
| chip_im | input | 8 | Chip read data, imaginary part |
| busy | output | 1 | A symbol is being processed or waits to be taken |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| y_re | output | 8 | Refined estimate, real part |
| y_im | output | 8 | Refined estimate, imaginary part |

## Verification
A reference model in the bench counts rising edges from the accepted start. From that count it derives the current path and the chip position within the pass. It then predicts, for every cycle, the read strobe and address, the `busy` flag, and `out_valid`, which is due at edge (`sf_len`+3)×`n_paths`. The expected symbol is computed arithmetically from the chip buffer contents at that edge. It is compared on every cycle while the result waits. The bench drives inputs on falling edges and compares shortly after rising edges, so each comparison sees the register state that the latest edge produced.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT
  } mf_state_e;

  // Clamp a signed value to the range of a two's-complement field of 'bits' width.
  function automatic int clamp_s(input int v, input int bits);
    int hi;
    int lo;
    hi = (1 << (bits - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/mf_chipmul.sv
// Descramble and despread one chip: c * conj(s) * spread, using sign flips only.
module mf_chipmul #(
  parameter  int W  = 8,
  localparam int OW = W + 2
) (
  input  logic signed [W-1:0]  re_i,
  input  logic signed [W-1:0]  im_i,
  input  logic                 si_neg,
  input  logic                 sq_neg,
  input  logic                 sp_neg,
  output logic signed [OW-1:0] dr_o,
  output logic signed [OW-1:0] di_o
);
  logic signed [OW-1:0] a, b, a_si, b_sq, b_si, a_sq, r0, i0;

  always_comb begin
    a    = OW'(re_i);
    b    = OW'(im_i);
    a_si = si_neg ? -a : a;
    b_sq = sq_neg ? -b : b;
    b_si = si_neg ? -b : b;
    a_sq = sq_neg ? -a : a;
    r0   = a_si + b_sq;
    i0   = b_si - a_sq;
    dr_o = sp_neg ? -r0 : r0;
    di_o = sp_neg ? -i0 : i0;
  end
endmodule

// File: rtl/mf_pathmul.sv
// Path correction: despread value times the conjugate of the path coefficient.
module mf_pathmul import mf_pkg::*; #(
  parameter int W   = 8,
  parameter int PRW = 16
) (
  input  logic signed [W-1:0]   h_re,
  input  logic signed [W-1:0]   h_im,
  input  logic signed [W-1:0]   g_re,
  input  logic signed [W-1:0]   g_im,
  output logic signed [PRW-1:0] p_re,
  output logic signed [PRW-1:0] p_im
);
  int full_re, full_im;

  always_comb begin
    full_re = int'(h_re) * int'(g_re) + int'(h_im) * int'(g_im);
    full_im = int'(h_im) * int'(g_re) - int'(h_re) * int'(g_im);
    p_re    = PRW'(clamp_s(full_re, PRW));
    p_im    = PRW'(clamp_s(full_im, PRW));
  end
endmodule

// File: rtl/mf_seq.sv
// Pass and path sequencer with the output handshake.
module mf_seq import mf_pkg::*; #(
  parameter int SFW = 5,
  parameter int LW  = 3,
  parameter int CW  = 5,
  parameter int PWD = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           out_ready,
  input  logic [SFW-1:0] sf_len,
  input  logic [LW-1:0]  n_paths,
  output logic           busy,
  output logic           out_valid,
  output logic           launch,
  output logic           rd_en,
  output logic           acc_en,
  output logic           hold_en,
  output logic           pc_en,
  output logic           fin,
  output logic [CW-1:0]  chip_idx,
  output logic [PWD-1:0] path_idx
);
  mf_state_e st;
  logic      run, pass_end, path_last;
  logic [CW-1:0] sf_c;

  assign sf_c      = CW'(sf_len);
  assign run       = (st == ST_RUN);
  assign pass_end  = (chip_idx == sf_c + CW'(2));
  assign path_last = ((PWD+1)'(path_idx) + (PWD+1)'(1)) == (PWD+1)'(n_paths);

  assign busy      = (st != ST_IDLE);
  assign out_valid = (st == ST_WAIT);
  assign launch    = (st == ST_IDLE) && start;
  assign rd_en     = run && (chip_idx < sf_c);
  assign acc_en    = run && (chip_idx != '0) && (chip_idx <= sf_c);
  assign hold_en   = run && (chip_idx == sf_c + CW'(1));
  assign pc_en     = run && pass_end;
  assign fin       = pc_en && path_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      chip_idx <= '0;
      path_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_RUN;
          chip_idx <= '0;
          path_idx <= '0;
        end
        ST_RUN: if (pass_end) begin
          chip_idx <= '0;
          if (path_last) st <= ST_WAIT;
          else path_idx <= path_idx + PWD'(1);
        end else begin
          chip_idx <= chip_idx + CW'(1);
        end
        ST_WAIT: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: no buffer reads without a symbol in progress
  a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en);
  // R10: only taking the result ends a busy period
  a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(out_valid && out_ready) |=> busy);
  // R9: a waiting result is not withdrawn
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
endmodule

// File: rtl/despread_mf.sv
module despread_mf import mf_pkg::*; #(
  parameter  int W         = 8,
  parameter  int SF_MAX    = 16,
  parameter  int L_MAX     = 6,
  parameter  int BUF_DEPTH = 64,
  parameter  int PRW       = 16,
  parameter  int DS_SH     = 2,
  parameter  int NORM_SH   = 6,
  localparam int AW        = $clog2(BUF_DEPTH),
  localparam int SFW       = $clog2(SF_MAX + 1),
  localparam int LW        = $clog2(L_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SFW-1:0]           sf_len,
  input  logic [LW-1:0]            n_paths,
  input  logic [2*SF_MAX-1:0]      scr_code,
  input  logic [SF_MAX-1:0]        spr_code,
  input  logic [L_MAX*2*W-1:0]     coef_flat,
  input  logic [L_MAX*AW-1:0]      dly_flat,
  input  logic signed [W-1:0]      y_prev_re,
  input  logic signed [W-1:0]      y_prev_im,
  output logic                     chip_rd,
  output logic [AW-1:0]            chip_addr,
  input  logic signed [W-1:0]      chip_re,
  input  logic signed [W-1:0]      chip_im,
  output logic                     busy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [W-1:0]      y_re,
  output logic signed [W-1:0]      y_im
);
  localparam int CW   = $clog2(SF_MAX + 3);
  localparam int PWD  = (L_MAX > 1) ? $clog2(L_MAX) : 1;
  localparam int ACCW = W + 2 + $clog2(SF_MAX);
  localparam int PACW = PRW + $clog2(L_MAX + 1);

  // Unpacked views of the per-path and per-chip inputs
  logic signed [W-1:0] g_re [L_MAX];
  logic signed [W-1:0] g_im [L_MAX];
  logic [AW-1:0]       dly  [L_MAX];
  logic                s_i_neg [SF_MAX];
  logic                s_q_neg [SF_MAX];

  for (genvar g = 0; g < L_MAX; g++) begin : g_path
    assign g_re[g] = coef_flat[g*2*W +: W];
    assign g_im[g] = coef_flat[g*2*W + W +: W];
    assign dly[g]  = dly_flat[g*AW +: AW];
  end
  for (genvar n = 0; n < SF_MAX; n++) begin : g_chip
    assign s_i_neg[n] = scr_code[2*n];
    assign s_q_neg[n] = scr_code[2*n + 1];
  end

  logic           launch, rd_en, acc_en, hold_en, pc_en, fin;
  logic [CW-1:0]  chip_idx;
  logic [PWD-1:0] path_idx;

  mf_seq #(.SFW(SFW), .LW(LW), .CW(CW), .PWD(PWD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .sf_len(sf_len), .n_paths(n_paths), .busy(busy), .out_valid(out_valid),
    .launch(launch), .rd_en(rd_en), .acc_en(acc_en), .hold_en(hold_en),
    .pc_en(pc_en), .fin(fin), .chip_idx(chip_idx), .path_idx(path_idx)
  );

  assign chip_rd   = rd_en;
  assign chip_addr = dly[path_idx] + AW'(chip_idx);

  // Data arriving now belongs to the chip addressed one cycle earlier
  logic [CW-1:0] code_idx;
  logic          code_ok, ci_neg, cq_neg, cs_neg;
  always_comb begin
    code_idx = (chip_idx == '0) ? '0 : chip_idx - CW'(1);
    code_ok  = (code_idx < CW'(SF_MAX));
    ci_neg   = code_ok ? s_i_neg[code_idx] : 1'b0;
    cq_neg   = code_ok ? s_q_neg[code_idx] : 1'b0;
    cs_neg   = code_ok ? spr_code[code_idx] : 1'b0;
  end

  logic signed [W+1:0] d_re, d_im;
  mf_chipmul #(.W(W)) u_chip (
    .re_i(chip_re), .im_i(chip_im), .si_neg(ci_neg), .sq_neg(cq_neg),
    .sp_neg(cs_neg), .dr_o(d_re), .di_o(d_im)
  );

  logic signed [ACCW-1:0] acc_re, acc_im;
  logic signed [W-1:0]    h_re, h_im;
  logic signed [PRW-1:0]  p_re, p_im;
  logic signed [PACW-1:0] pacc_re, pacc_im, pnx_re, pnx_im;
  int                     fin_re, fin_im;

  mf_pathmul #(.W(W), .PRW(PRW)) u_path (
    .h_re(h_re), .h_im(h_im), .g_re(g_re[path_idx]), .g_im(g_im[path_idx]),
    .p_re(p_re), .p_im(p_im)
  );

  always_comb begin
    pnx_re = pacc_re + PACW'(p_re);
    pnx_im = pacc_im + PACW'(p_im);
    fin_re = clamp_s(clamp_s(int'(pnx_re) >>> NORM_SH, W) + int'(y_prev_re), W);
    fin_im = clamp_s(clamp_s(int'(pnx_im) >>> NORM_SH, W) + int'(y_prev_im), W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re  <= '0;
      acc_im  <= '0;
      h_re    <= '0;
      h_im    <= '0;
      pacc_re <= '0;
      pacc_im <= '0;
      y_re    <= '0;
      y_im    <= '0;
    end else begin
      if (launch || pc_en) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (acc_en) begin
        acc_re <= acc_re + ACCW'(d_re);
        acc_im <= acc_im + ACCW'(d_im);
      end
      if (hold_en) begin
        h_re <= W'(clamp_s(int'(acc_re) >>> DS_SH, W));
        h_im <= W'(clamp_s(int'(acc_im) >>> DS_SH, W));
      end
      if (launch) begin
        pacc_re <= '0;
        pacc_im <= '0;
      end else if (pc_en) begin
        pacc_re <= pnx_re;
        pacc_im <= pnx_im;
      end
      if (fin) begin
        y_re <= W'(fin_re);
        y_im <= W'(fin_im);
      end
    end
  end

  // R3: reads within a pass walk consecutive buffer addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rd && $past(chip_rd) |-> chip_addr == $past(chip_addr) + AW'(1));
  // R9: a waiting result keeps its value
  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(y_re) && $stable(y_im));
  // R2: a result is only offered inside a busy period
  a_r2_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
endmodule

// File: tb/despread_mf_tb_top.sv
module despread_mf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start = 1'b0;
  logic              out_ready = 1'b0;
  logic [4:0]        sf_len;
  logic [2:0]        n_paths;
  logic [31:0]       scr_code;
  logic [15:0]       spr_code;
  logic [95:0]       coef_flat;
  logic [35:0]       dly_flat;
  logic signed [7:0] y_prev_re, y_prev_im;
  logic              chip_rd;
  logic [5:0]        chip_addr;
  logic signed [7:0] chip_re = '0, chip_im = '0;
  logic              busy, out_valid;
  logic signed [7:0] y_re, y_im;

  despread_mf dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sf_len(sf_len), .n_paths(n_paths),
    .scr_code(scr_code), .spr_code(spr_code), .coef_flat(coef_flat),
    .dly_flat(dly_flat), .y_prev_re(y_prev_re), .y_prev_im(y_prev_im),
    .chip_rd(chip_rd), .chip_addr(chip_addr), .chip_re(chip_re), .chip_im(chip_im),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .y_re(y_re), .y_im(y_im)
  );

  // Stimulus state
  int   np = 1, sf = 16, yp_re = 0, yp_im = 0;
  int   cr [6], ci [6], dl [6];
  logic sc_i [16], sc_q [16], sp [16];
  int   mem_re [64], mem_im [64];
  string cur_tag = "reset";

  always_comb begin
    sf_len    = 5'(sf);
    n_paths   = 3'(np);
    y_prev_re = 8'(yp_re);
    y_prev_im = 8'(yp_im);
    for (int g = 0; g < 6; g++) begin
      coef_flat[g*16 +: 8]     = 8'(cr[g]);
      coef_flat[g*16 + 8 +: 8] = 8'(ci[g]);
      dly_flat[g*6 +: 6]       = 6'(dl[g]);
    end
    for (int n = 0; n < 16; n++) begin
      scr_code[2*n]     = sc_i[n];
      scr_code[2*n + 1] = sc_q[n];
      spr_code[n]       = sp[n];
    end
  end

  // External chip buffer, one cycle read latency
  always @(posedge clk) if (chip_rd) begin
    chip_re <= 8'(mem_re[chip_addr]);
    chip_im <= 8'(mem_im[chip_addr]);
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clip(input int v, input int bits);
    int hi = (1 << (bits - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  // Expected symbol from the requirement arithmetic
  function automatic void expect_sym(output int er, output int ei);
    int tr = 0, ti = 0;
    for (int p = 0; p < np; p++) begin
      int sr = 0, si = 0, hr, hi;
      for (int n = 0; n < sf; n++) begin
        int a = mem_re[(dl[p] + n) % 64];
        int b = mem_im[(dl[p] + n) % 64];
        int s1 = sc_i[n] ? -1 : 1;
        int s2 = sc_q[n] ? -1 : 1;
        int k  = sp[n] ? -1 : 1;
        sr += k * (a * s1 + b * s2);
        si += k * (b * s1 - a * s2);
      end
      hr = clip(sr >>> 2, 8);
      hi = clip(si >>> 2, 8);
      tr += clip(hr * cr[p] + hi * ci[p], 16);
      ti += clip(hi * cr[p] - hr * ci[p], 16);
    end
    er = clip(clip(tr >>> 6, 8) + yp_re, 8);
    ei = clip(clip(ti >>> 6, 8) + yp_im, 8);
  endfunction

  // Cycle reference model, compared after every rising edge
  bit m_busy = 0, m_valid = 0;
  int m_cnt = 0, m_total = 0, m_er = 0, m_ei = 0;

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_cnt = 0;
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(chip_rd == 1'b0, "R1 chip_rd in reset", int'(chip_rd), 0);
    end else begin
      bit exp_rd;
      int c, p;
      if (m_valid) begin
        if (out_ready) begin m_valid = 0; m_busy = 0; end
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_total) begin
          m_valid = 1;
          expect_sym(m_er, m_ei);
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_total = (sf + 3) * np;
      end
      c = m_cnt % (sf + 3);
      p = m_cnt / (sf + 3);
      exp_rd = m_busy && !m_valid && (c < sf);
      chk(busy == m_busy, {"R2 R10 busy ", cur_tag}, int'(busy), int'(m_busy));
      chk(out_valid == m_valid, {"R8 R9 out_valid ", cur_tag}, int'(out_valid), int'(m_valid));
      chk(chip_rd == exp_rd, {"R3 chip_rd ", cur_tag}, int'(chip_rd), int'(exp_rd));
      if (exp_rd)
        chk(int'(chip_addr) == (dl[p] + c) % 64, {"R3 chip_addr ", cur_tag},
            int'(chip_addr), (dl[p] + c) % 64);
      if (m_valid) begin
        chk(int'(y_re) == m_er, {"R7 R9 y_re ", cur_tag}, int'(y_re), m_er);
        chk(int'(y_im) == m_ei, {"R7 R9 y_im ", cur_tag}, int'(y_im), m_ei);
      end
    end
  end

  // One symbol: optional extra start pulses while busy (R10)
  task automatic run_sym(input string tag, input int wait_rdy, input bit poke);
    @(negedge clk);
    cur_tag = tag;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!m_valid) @(negedge clk);
    if (poke) start = 1'b1;
    repeat (wait_rdy) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    start = 1'b0;
  endtask

  task automatic set_codes(input int seed);
    for (int n = 0; n < 16; n++) begin
      sc_i[n] = ((n * 7 + seed) % 3) == 0;
      sc_q[n] = ((n * 5 + seed) % 4) < 2;
      sp[n]   = ((n * 3 + seed) % 5) > 2;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_re[i] = ((i * 37 + 11) % 256) - 128;
      mem_im[i] = ((i * 53 + 90) % 256) - 128;
    end
    for (int g = 0; g < 6; g++) begin
      cr[g] = 0; ci[g] = 0; dl[g] = 0;
    end
    set_codes(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6: one path at full spreading factor
    np = 1; sf = 16; dl[0] = 0; cr[0] = 100; ci[0] = -30; yp_re = 0; yp_im = 0;
    run_sym("R4 R5 R6 single path", 0, 0);

    // R6 R7 R10: six paths, wrap-around delay, late ready, stray start pulses
    np = 6; set_codes(2); yp_re = 10; yp_im = -20;
    dl[0] = 0; dl[1] = 5; dl[2] = 17; dl[3] = 33; dl[4] = 50; dl[5] = 60;
    cr[0] = 90;  ci[0] = 12;  cr[1] = -45; ci[1] = 70;  cr[2] = 33;  ci[2] = -99;
    cr[3] = -128; ci[3] = 5;  cr[4] = 64;  ci[4] = 64;  cr[5] = 1;   ci[5] = -128;
    run_sym("R6 R7 R10 six paths", 3, 1);

    // R3 R8: short spreading factor, three paths, back to back
    np = 3; sf = 4; set_codes(3); dl[0] = 9; dl[1] = 40; dl[2] = 62;
    run_sym("R3 R8 short sf", 0, 0);

    // R5 R6 R7: saturation of despread value, product and final sum
    for (int i = 0; i < 16; i++) begin mem_re[i] = -128; mem_im[i] = 0; end
    for (int n = 0; n < 16; n++) begin sc_i[n] = 1'b0; sc_q[n] = 1'b1; sp[n] = 1'b0; end
    np = 1; sf = 16; dl[0] = 0; cr[0] = -128; ci[0] = -128; yp_re = 100; yp_im = -50;
    run_sym("R5 R6 R7 saturation", 2, 0);

    // R3 R9: two paths, spreading factor 8, long back-pressure
    np = 2; sf = 8; set_codes(4); dl[0] = 20; dl[1] = 41; cr[0] = -77; ci[0] = 31;
    cr[1] = 50; ci[1] = -6; yp_re = -5; yp_im = 7;
    run_sym("R3 R9 held result", 6, 1);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog R8 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule